// File: doc/BRIEF.md
# Capture/Compare PWM Timer

This block is a general-purpose timer for pulse-width modulation and input timing. A 16-bit counter runs from a clock enable that comes out of a programmable prescaler, which divides the input clock by any integer from 1 to 1024. The counter wraps at a programmable top value, which acts as its reload value. It runs in one of two forms. In edge-aligned counting it rises from zero to the top value and then returns to zero. In center-aligned counting it rises to the top value and then falls back to zero.

Four compare channels turn the count into PWM waveforms, and each channel has its own output polarity. Compare values are written into shadow registers. They move into the working compare registers only at the period boundary, so a waveform never changes partway through a period.

Two capture inputs are synchronized and then noise-filtered on the prescaled clock. A filtered edge of the selected direction latches the current count, increments an 8-bit event counter for that input and raises an interrupt flag. Software programs the block through a single-port register interface. Writes are synchronous and reads are combinational.

Top module: `capcmp_pwm`

## Requirements
- R1: After reset every register reads zero, every PWM output is 0 and every interrupt flag is 0.
- R2: The prescale register (address 1, 10 bits) holding value v produces one count step every v+1 clock cycles, so 0 divides by 1 and 1023 divides by 1024. The register reads back what was written.
- R3: Edge-aligned mode (control bit 1 = 0, run = control bit 0) counts 0,1,…,top and then returns to 0, where top is register 2. One period is top+1 steps. The wrap to 0 sets the overflow flag (flag register address 3, bit 0, also the ovfIrq port).
- R4: Center-aligned mode (control bit 1 = 1) counts from 0 up to top and back down to 0. One period is 2·top steps. The return to 0 sets the overflow flag.
- R5: A PWM channel i is active while the count is below its working compare value. A compare value of 0 gives no active time. A value above top gives full active time. Each period is therefore active for c steps (edge-aligned) or 2c−1 steps (center-aligned, 1 ≤ c ≤ top).
- R6: Control bit 2+i set inverts output i. While run is 0 every output rests at its polarity bit.
- R7: A write to a compare register (address 4+i) affects the output only from the next period boundary, or at once while the timer is stopped.
- R8: A capture input passes two synchronizer stages. Its level is accepted only after four consecutive equal samples on the prescaled clock, so a pulse shorter than four steps is ignored.
- R9: An accepted edge that matches control bit 6+j (0 = rising, 1 = falling) latches the count into capture register 8+j, increments the event counter at address 10+j and sets flag bit 1+j. At divide-by-one the latched value is the count read at the input change plus 5. Edges in the other direction change nothing.
- R10: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the addressed register |
| capIn | input | 2 | Capture inputs |
| pwmOut | output | 4 | PWM outputs |
| ovfIrq | output | 1 | Overflow flag |
| capIrq | output | 2 | Capture flags |

## Verification
The bench sweeps both counting forms over several prescale and top settings. On each channel it uses compare values of zero, mid-range, exactly top and beyond top. An off-by-one in the wrap or the turnaround shows up as a wrong overflow spacing or a duty count that is one step off.

A prescale of 1023 checks that the divider reaches 1024 instead of truncating. A compare value rewritten just after a boundary must leave the current period untouched. A design that updates the working register at once would show the new duty one period early.

Capture pulses of three and four steps probe the filter threshold, where a miscount either lets a glitch through or drops a valid edge. The captured value is checked against the count seen when the input changed, so an extra or missing pipeline stage is caught.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  typedef struct packed {
    logic tick;
    logic clrOvf;
  } capcmpStrobe_t;

  localparam logic [3:0] ADR_CTRL  = 4'd0;
  localparam logic [3:0] ADR_PRESC = 4'd1;
  localparam logic [3:0] ADR_TOP   = 4'd2;
  localparam logic [3:0] ADR_FLAGS = 4'd3;
  localparam logic [3:0] ADR_CMP0  = 4'd4;
  localparam logic [3:0] ADR_CAP0  = 4'd8;
  localparam logic [3:0] ADR_EVT0  = 4'd10;
  localparam logic [3:0] ADR_COUNT = 4'd12;
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int TW   = 16,
  parameter int PW   = 10,
  parameter int NCMP = 4,
  parameter int NCAP = 2,
  parameter int ECW  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [3:0]           regAddr,
  input  logic [TW-1:0]        wrData,
  input  logic [TW-1:0]        cntVal,
  input  logic [NCAP*TW-1:0]   capFlat,
  input  logic [NCAP*ECW-1:0]  evtFlat,
  input  logic [NCAP:0]        flags,
  output logic [TW-1:0]        rdData,
  output capcmpStrobe_t        strobe,
  output logic [NCAP-1:0]      clrCap,
  output logic                 run,
  output logic                 center,
  output logic [NCMP-1:0]      polarity,
  output logic [NCAP-1:0]      edgeSel,
  output logic [PW-1:0]        presc,
  output logic [TW-1:0]        top,
  output logic [NCMP*TW-1:0]   cmpShadow
);
  localparam int CTRL_W = 2 + NCMP + NCAP;

  logic [CTRL_W-1:0] ctrlReg;
  logic [PW-1:0]     preCnt;
  logic [TW-1:0]     cmpReg [NCMP];
  logic              flagWr;

  assign run      = ctrlReg[0];
  assign center   = ctrlReg[1];
  assign polarity = ctrlReg[2 +: NCMP];
  assign edgeSel  = ctrlReg[2+NCMP +: NCAP];
  assign flagWr   = wrEn && (regAddr == ADR_FLAGS);

  assign strobe.tick   = run && (preCnt == presc);
  assign strobe.clrOvf = flagWr && wrData[0];
  assign clrCap        = flagWr ? wrData[NCAP:1] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      presc   <= '0;
      top     <= '0;
    end else if (wrEn) begin
      if (regAddr == ADR_CTRL)  ctrlReg <= wrData[CTRL_W-1:0];
      if (regAddr == ADR_PRESC) presc   <= wrData[PW-1:0];
      if (regAddr == ADR_TOP)   top     <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run || strobe.tick) preCnt <= '0;
    else                              preCnt <= preCnt + PW'(1);
  end

  for (genvar i = 0; i < NCMP; i++) begin : gCmp
    localparam logic [3:0] MY_ADR = 4'(ADR_CMP0 + i);
    always_ff @(posedge clk) begin
      if (!rstN) cmpReg[i] <= '0;
      else if (wrEn && regAddr == MY_ADR) cmpReg[i] <= wrData;
    end
    assign cmpShadow[i*TW +: TW] = cmpReg[i];
  end

  always_comb begin
    rdData = '0;
    if (regAddr == ADR_CTRL)  rdData = TW'(ctrlReg);
    if (regAddr == ADR_PRESC) rdData = TW'(presc);
    if (regAddr == ADR_TOP)   rdData = top;
    if (regAddr == ADR_FLAGS) rdData = TW'(flags);
    if (regAddr == ADR_COUNT) rdData = cntVal;
    for (int i = 0; i < NCMP; i++)
      if (regAddr == 4'(ADR_CMP0 + i)) rdData = cmpReg[i];
    for (int j = 0; j < NCAP; j++) begin
      if (regAddr == 4'(ADR_CAP0 + j)) rdData = capFlat[j*TW +: TW];
      if (regAddr == 4'(ADR_EVT0 + j)) rdData = TW'(evtFlat[j*ECW +: ECW]);
    end
  end
endmodule

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
#(
  parameter int TW       = 16,
  parameter int NCMP     = 4,
  parameter int NCAP     = 2,
  parameter int ECW      = 8,
  parameter int FILT_LEN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  capcmpStrobe_t       strobe,
  input  logic [NCAP-1:0]     clrCap,
  input  logic                run,
  input  logic                center,
  input  logic [NCMP-1:0]     polarity,
  input  logic [NCAP-1:0]     edgeSel,
  input  logic [TW-1:0]       top,
  input  logic [NCMP*TW-1:0]  cmpShadow,
  input  logic [NCAP-1:0]     capIn,
  output logic [TW-1:0]       cntVal,
  output logic [NCAP*TW-1:0]  capFlat,
  output logic [NCAP*ECW-1:0] evtFlat,
  output logic [NCAP:0]       flags,
  output logic [NCMP-1:0]     pwmOut
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0]   cntNext;
  logic            countDown, dirNext, boundary, goDown, ovfFlag;
  logic [TW-1:0]   cmpAct [NCMP];
  logic [NCAP-1:0] capFlags;

  always_comb begin
    cntNext  = cntVal;
    dirNext  = countDown;
    boundary = 1'b0;
    goDown   = countDown || (cntVal >= top);
    if (!run) begin
      cntNext = '0;
      dirNext = 1'b0;
    end else if (strobe.tick) begin
      if (!center) begin
        dirNext = 1'b0;
        if (cntVal >= top) begin
          cntNext  = '0;
          boundary = 1'b1;
        end else cntNext = cntVal + ONE;
      end else if (top == '0 || cntVal == '0 && countDown) begin
        cntNext = '0;
        dirNext = 1'b0;
      end else if (goDown) begin
        cntNext = cntVal - ONE;
        dirNext = 1'b1;
        if (cntVal == ONE) begin
          dirNext  = 1'b0;
          boundary = 1'b1;
        end
      end else cntNext = cntVal + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal    <= '0;
      countDown <= 1'b0;
      ovfFlag   <= 1'b0;
      pwmOut    <= '0;
      for (int i = 0; i < NCMP; i++) cmpAct[i] <= '0;
    end else begin
      cntVal    <= cntNext;
      countDown <= dirNext;
      if (boundary)           ovfFlag <= 1'b1;
      else if (strobe.clrOvf) ovfFlag <= 1'b0;
      for (int i = 0; i < NCMP; i++) begin
        if (!run || boundary) cmpAct[i] <= cmpShadow[i*TW +: TW];
        pwmOut[i] <= run ? ((cntVal < cmpAct[i]) ^ polarity[i]) : polarity[i];
      end
    end
  end

  for (genvar j = 0; j < NCAP; j++) begin : gCap
    logic                s1, s2, level, flagQ, allSame, hit;
    logic [FILT_LEN-2:0] hist;
    logic [FILT_LEN-1:0] window;
    logic [TW-1:0]       capQ;
    logic [ECW-1:0]      evtQ;

    assign window  = {hist, s2};
    assign allSame = (&window) | ~(|window);
    assign hit     = strobe.tick && allSame && (window[0] != level)
                     && (window[0] != edgeSel[j]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        s1 <= 1'b0; s2 <= 1'b0; level <= 1'b0; flagQ <= 1'b0;
        hist <= '0; capQ <= '0; evtQ <= '0;
      end else begin
        s1 <= capIn[j];
        s2 <= s1;
        if (strobe.tick) begin
          hist <= window[FILT_LEN-2:0];
          if (allSame) level <= window[0];
        end
        if (hit) begin
          capQ  <= cntVal;
          evtQ  <= evtQ + ECW'(1);
          flagQ <= 1'b1;
        end else if (clrCap[j]) flagQ <= 1'b0;
      end
    end

    assign capFlags[j]            = flagQ;
    assign capFlat[j*TW +: TW]    = capQ;
    assign evtFlat[j*ECW +: ECW]  = evtQ;
  end

  assign flags = {capFlags, ovfFlag};
endmodule

// File: rtl/capcmp_pwm.sv
module capcmp_pwm
  import capcmp_pkg::*;
#(
  parameter int TW       = 16,
  parameter int PW       = 10,
  parameter int NCMP     = 4,
  parameter int NCAP     = 2,
  parameter int ECW      = 8,
  parameter int FILT_LEN = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [3:0]      regAddr,
  input  logic [TW-1:0]   wrData,
  output logic [TW-1:0]   rdData,
  input  logic [NCAP-1:0] capIn,
  output logic [NCMP-1:0] pwmOut,
  output logic            ovfIrq,
  output logic [NCAP-1:0] capIrq
);
  capcmpStrobe_t        strobe;
  logic                 tickStrobe, run, center;
  logic [NCAP-1:0]      clrCap, edgeSel;
  logic [NCMP-1:0]      polarity;
  logic [PW-1:0]        presc;
  logic [TW-1:0]        top, cntVal;
  logic [NCMP*TW-1:0]   cmpShadow;
  logic [NCAP*TW-1:0]   capFlat;
  logic [NCAP*ECW-1:0]  evtFlat;
  logic [NCAP:0]        flags;

  assign tickStrobe = strobe.tick;
  assign ovfIrq     = flags[0];
  assign capIrq     = flags[NCAP:1];

  capcmp_ctrl #(.TW(TW), .PW(PW), .NCMP(NCMP), .NCAP(NCAP), .ECW(ECW)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .cntVal(cntVal), .capFlat(capFlat), .evtFlat(evtFlat), .flags(flags),
    .rdData(rdData), .strobe(strobe), .clrCap(clrCap), .run(run),
    .center(center), .polarity(polarity), .edgeSel(edgeSel), .presc(presc),
    .top(top), .cmpShadow(cmpShadow)
  );

  capcmp_datapath #(.TW(TW), .NCMP(NCMP), .NCAP(NCAP), .ECW(ECW),
                    .FILT_LEN(FILT_LEN)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clrCap(clrCap), .run(run),
    .center(center), .polarity(polarity), .edgeSel(edgeSel), .top(top),
    .cmpShadow(cmpShadow), .capIn(capIn), .cntVal(cntVal), .capFlat(capFlat),
    .evtFlat(evtFlat), .flags(flags), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/capcmp_checker.sv
module capcmp_checker #(
  parameter int TW   = 16,
  parameter int PW   = 10,
  parameter int NCMP = 4,
  parameter int NCAP = 2,
  parameter int ECW  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                tick,
  input logic                run,
  input logic                center,
  input logic [PW-1:0]       presc,
  input logic [TW-1:0]       top,
  input logic [TW-1:0]       cntVal,
  input logic [NCMP-1:0]     polarity,
  input logic [NCMP-1:0]     pwmOut,
  input logic                ovfIrq,
  input logic [NCAP-1:0]     capIrq,
  input logic [NCAP*ECW-1:0] evtFlat
);
  assert_presc_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && presc != '0) |=> (!tick || presc == '0));

  assert_edge_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (run && tick && !center && cntVal == top) |=> cntVal == '0);

  assert_ovf_at_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfIrq) |-> cntVal == '0);

  assert_center_turn_R4: assert property (@(posedge clk) disable iff (!rstN)
    (run && tick && center && top > TW'(1) && cntVal == top)
      |=> (!run || cntVal + TW'(1) == $past(cntVal)));

  assert_stop_rest_R6: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> pwmOut == $past(polarity));

  for (genvar j = 0; j < NCAP; j++) begin : gCapChk
    assert_capture_counts_R9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(capIrq[j]) |-> evtFlat[j*ECW +: ECW] != $past(evtFlat[j*ECW +: ECW]));
  end
endmodule

bind capcmp_pwm capcmp_checker #(.TW(TW), .PW(PW), .NCMP(NCMP), .NCAP(NCAP), .ECW(ECW))
  uChk (.clk(clk), .rstN(rstN), .tick(tickStrobe), .run(run), .center(center),
        .presc(presc), .top(top), .cntVal(cntVal), .polarity(polarity),
        .pwmOut(pwmOut), .ovfIrq(ovfIrq), .capIrq(capIrq), .evtFlat(evtFlat));

// File: tb/sim_capcmp_pwm.sv
module sim_capcmp_pwm;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  capIn = '0;
  logic [3:0]  pwmOut;
  logic        ovfIrq;
  logic [1:0]  capIrq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  capcmp_pwm u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .capIn(capIn), .pwmOut(pwmOut),
    .ovfIrq(ovfIrq), .capIrq(capIrq));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    regAddr = 4'(a); wrData = 16'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    regAddr = 4'(a);
    #1 v = int'(rdData);
  endtask

  function automatic int ctrlWord(int runB, int cen, int pol, int edg);
    return runB | (cen << 1) | (pol << 2) | (edg << 6);
  endfunction

  function automatic int dutySteps(int cen, int c, int top);
    if (!cen) return (c <= top) ? c : top + 1;
    if (c == 0) return 0;
    return (c <= top) ? 2 * c - 1 : 2 * top;
  endfunction

  task automatic runPwm(input int cen, input int presc, input int top, input int pol);
    int cmp[4];
    int act[4];
    int perCyc, cnt, v;
    string tagP;
    cmp[0] = 0; cmp[1] = 2; cmp[2] = top; cmp[3] = top + 1;
    perCyc = (cen ? 2 * top : top + 1) * (presc + 1);
    tagP = cen ? "R4" : "R3";
    wr(0, 0);
    wr(1, presc);
    rd(1, v);
    chk("R2 prescale readback", v, presc);
    wr(2, top);
    for (int i = 0; i < 4; i++) wr(4 + i, cmp[i]);
    wr(3, 1);
    wr(0, ctrlWord(1, cen, pol, 0));
    while (!ovfIrq) @(negedge clk);
    wr(3, 1);
    cnt = 1;
    while (!ovfIrq) begin @(negedge clk); cnt++; end
    chk({tagP, " R2 overflow spacing"}, cnt, perCyc);
    for (int i = 0; i < 4; i++) act[i] = 0;
    for (int k = 0; k < 2 * perCyc; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if (pwmOut[i]) act[i]++;
    end
    for (int i = 0; i < 4; i++) begin
      int e = 2 * dutySteps(cen, cmp[i], top) * (presc + 1);
      if ((pol >> i) & 1) e = 2 * perCyc - e;
      chk(((pol >> i) & 1) ? "R6 inverted duty" : "R5 duty", act[i], e);
    end
  endtask

  initial begin
    int v, t, c1, c2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm", int'(pwmOut), 0);
    chk("R1 ovf", int'(ovfIrq), 0);
    chk("R1 cap flags", int'(capIrq), 0);
    rd(12, v); chk("R1 count", v, 0);
    rd(2, v);  chk("R1 top", v, 0);
    rd(10, v); chk("R1 event", v, 0);

    runPwm(0, 0, 5, 0);
    runPwm(0, 2, 5, 0);
    runPwm(1, 0, 5, 0);
    runPwm(1, 2, 4, 4'b1010);
    runPwm(0, 1, 3, 4'b0101);
    runPwm(1, 0, 1, 0);
    runPwm(0, 1023, 1, 0);   // R2 largest divide

    // R6 rest level while stopped
    wr(0, ctrlWord(0, 0, 4'b1010, 0));
    @(negedge clk);
    chk("R6 stopped outputs", int'(pwmOut), 4'b1010);

    // R7 compare double buffering
    wr(1, 0); wr(2, 9); wr(4, 5); wr(3, 1);
    wr(0, ctrlWord(1, 0, 0, 0));
    while (!ovfIrq) @(negedge clk);
    c1 = 0;
    fork
      begin
        repeat (10) begin @(negedge clk); if (pwmOut[0]) c1++; end
      end
      begin
        wr(4, 2);
        wr(3, 1);
      end
    join
    c2 = 0;
    repeat (10) begin @(negedge clk); if (pwmOut[0]) c2++; end
    chk("R7 current period keeps old compare", c1, 5);
    chk("R7 next period uses new compare", c2, 2);

    // Capture: ch0 rising, ch1 falling, divide by one
    wr(0, 0); wr(2, 16'hFFFF);
    wr(0, ctrlWord(1, 0, 0, 2'b10));
    wr(3, 6);
    capIn[0] = 1'b1;
    repeat (3) @(negedge clk);
    capIn[0] = 1'b0;
    repeat (10) @(negedge clk);
    rd(10, v); chk("R8 short pulse ignored count", v, 0);
    chk("R8 short pulse no flag", int'(capIrq[0]), 0);

    rd(12, t);
    capIn[0] = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 ch0 flag", int'(capIrq[0]), 1);
    rd(8, v);  chk("R9 ch0 capture value", v, t + 5);
    rd(10, v); chk("R9 ch0 event count", v, 1);
    capIn[0] = 1'b0;
    repeat (8) @(negedge clk);
    rd(10, v); chk("R9 ch0 falling ignored", v, 1);
    wr(3, 2);
    chk("R10 ch0 flag cleared", int'(capIrq[0]), 0);

    capIn[1] = 1'b1;
    repeat (8) @(negedge clk);
    rd(11, v); chk("R9 ch1 rising ignored", v, 0);
    chk("R9 ch1 no flag on rising", int'(capIrq[1]), 0);
    rd(12, t);
    capIn[1] = 1'b0;
    repeat (8) @(negedge clk);
    rd(9, v);  chk("R9 ch1 capture value", v, t + 5);
    rd(11, v); chk("R9 ch1 event count", v, 1);
    wr(3, 2);
    chk("R10 zero bit leaves ch1 flag", int'(capIrq[1]), 1);
    wr(3, 4);
    chk("R10 ch1 flag cleared", int'(capIrq[1]), 0);

    capIn[0] = 1'b1;
    repeat (4) @(negedge clk);
    capIn[0] = 1'b0;
    repeat (10) @(negedge clk);
    rd(10, v); chk("R8 four-step pulse accepted", v, 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule